// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Enable Preamble

This block is the sending half of a full-duplex asynchronous serial port. A host writes a small control register (transmit enable, character length, ninth data bit) and a one-entry, write-only data buffer. The transmitter moves the buffered byte into an internal shift register and sends it on a single serial line, one bit for each pulse of a bit-rate enable. That enable comes from a baud generator outside the block.

When the enable bit goes from clear to set, the transmitter first sends one full character time of idle ones before any data. A flag tells the host when the buffer can take another byte. The flag is set in the cycle the buffer contents are transferred into the shift register, so the host can refill the buffer while a character is still being sent. Characters then follow one another with no gap. If the transmitter is disabled while the line is idle and the buffer is empty, it stops driving the line. An output-enable signal falling low models this.

Top module: `async_tx_preamble`

## Requirements
- R1: After reset the line output is 1, the output enable is 0 and the buffer-empty flag is 1.
- R2: A control write that changes the enable bit from 0 to 1 queues one preamble of all ones. It is 10 bit times long in 8-bit mode and 11 in 9-bit mode. It starts on the clock after the enable is stored and goes out before any buffered data.
- R3: A data character is sent LSB first, one bit per bit-rate pulse. The order is a 0 start bit, the 8 data bits, then (in 9-bit mode only) the stored ninth-bit control value, then a 1 stop bit.
- R4: A buffer write accepted while the flag is 1 clears the flag. The flag returns to 1 in the same clock that moves the buffer into the shift register. From an idle, enabled line, that move happens on the clock after the write.
- R5: A buffer write made while the flag is 0 is ignored. The byte sent next is the one already held.
- R6: If the buffer is full when a stop bit ends, the next start bit follows at once, with no idle bit time.
- R7: While enabled and not sending, the line output is 1 and the output enable is 1.
- R8: Clearing the enable bit while the line is idle and the buffer is empty drives the output enable to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle bit-rate enable pulse |
| ctl_we | input | 1 | Control register write strobe |
| ctl_tx_en | input | 1 | Written value of the transmit enable |
| ctl_nine | input | 1 | Written value of the 9-bit mode select |
| ctl_bit8 | input | 1 | Written value of the ninth data bit |
| buf_we | input | 1 | Data buffer write strobe |
| buf_wdata | input | DATA_W | Data buffer write value |
| txd | output | 1 | Serial line output |
| txd_oe | output | 1 | Serial line output enable |
| buf_empty | output | 1 | Buffer empty flag |

## Verification
The hardest situation to reach from the ports is a handover at the exact clock where a stop bit ends: the preamble into the first character, and each character into the next. The buffer must already be full at that clock. The stimulus refills the buffer early in every frame and then tries to overwrite it, which also tests rejection of writes while the flag is clear. It then checks the start bit in the sample right after the final stop-bit pulse. All 256 byte values are swept in 8-bit mode and in 9-bit mode with both ninth-bit values. Each sweep begins with a fresh enable, so the preamble length is checked in both modes.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  typedef enum logic [0:0] {
    SH_IDLE  = 1'b0,
    SH_SHIFT = 1'b1
  } sh_state_e;
endpackage

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  logic ctl_tx_en,
  input  logic ctl_nine,
  input  logic ctl_bit8,
  input  logic load_pre,
  output logic en_q,
  output logic nine_q,
  output logic bit8_q,
  output logic pre_q
);
  logic en_d, nine_d, bit8_d, pre_d;

  always_comb begin
    en_d   = en_q;
    nine_d = nine_q;
    bit8_d = bit8_q;
    if (ctl_we) begin
      en_d   = ctl_tx_en;
      nine_d = ctl_nine;
      bit8_d = ctl_bit8;
    end
    if (!en_d)
      pre_d = 1'b0;
    else if (!en_q)
      pre_d = 1'b1;
    else if (load_pre)
      pre_d = 1'b0;
    else
      pre_d = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      nine_q <= 1'b0;
      bit8_q <= 1'b0;
      pre_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      nine_q <= nine_d;
      bit8_q <= bit8_d;
      pre_q  <= pre_d;
    end
  end
endmodule

// File: rtl/async_tx_buffer.sv
module async_tx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_we,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic              xfer,
  output logic [DATA_W-1:0] data_q,
  output logic              empty_q
);
  logic              accept;
  logic [DATA_W-1:0] data_d;
  logic              empty_d;

  always_comb begin
    accept  = buf_we && empty_q;
    data_d  = accept ? buf_wdata : data_q;
    empty_d = empty_q;
    if (accept)
      empty_d = 1'b0;
    else if (xfer)
      empty_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else begin
      data_q  <= data_d;
      empty_q <= empty_d;
    end
  end
endmodule

// File: rtl/async_tx_shifter.sv
module async_tx_shifter
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              en,
  input  logic              nine,
  input  logic              bit8,
  input  logic              pre_pend,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_data,
  output logic              load_pre,
  output logic              load_data,
  output logic              busy,
  output logic              txd_bit
);
  localparam int FRAME_MAX = DATA_W + 3;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(FRAME_MAX);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(FRAME_MAX - 1);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  sh_state_e               state_q, state_d;
  logic [FRAME_MAX-1:0]    sh_q, sh_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic                    end_bit, slot_free;
  logic [CNT_W-1:0]        frame_len;
  logic [FRAME_MAX-1:0]    data_frame;

  always_comb begin
    busy      = (state_q == SH_SHIFT);
    end_bit   = busy && bit_tick && (cnt_q == CNT_ONE);
    slot_free = !busy || end_bit;
    load_pre  = slot_free && pre_pend;
    load_data = slot_free && !pre_pend && en && buf_full;
    frame_len = nine ? LEN_LONG : LEN_SHORT;
    data_frame = {1'b1, (nine ? bit8 : 1'b1), buf_data, 1'b0};

    state_d = state_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    if (load_pre) begin
      state_d = SH_SHIFT;
      sh_d    = '1;
      cnt_d   = frame_len;
    end else if (load_data) begin
      state_d = SH_SHIFT;
      sh_d    = data_frame;
      cnt_d   = frame_len;
    end else if (end_bit) begin
      state_d = SH_IDLE;
      sh_d    = '1;
      cnt_d   = '0;
    end else if (busy && bit_tick) begin
      sh_d  = {1'b1, sh_q[FRAME_MAX-1:1]};
      cnt_d = cnt_q - CNT_ONE;
    end

    txd_bit = busy ? sh_q[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      sh_q    <= '1;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/async_tx_preamble.sv
module async_tx_preamble #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              ctl_we,
  input  logic              ctl_tx_en,
  input  logic              ctl_nine,
  input  logic              ctl_bit8,
  input  logic              buf_we,
  input  logic [DATA_W-1:0] buf_wdata,
  output logic              txd,
  output logic              txd_oe,
  output logic              buf_empty
);
  logic              en_q, nine_q, bit8_q, pre_q;
  logic              load_pre, load_data, busy, txd_bit;
  logic [DATA_W-1:0] buf_data;

  async_tx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_tx_en (ctl_tx_en),
    .ctl_nine  (ctl_nine),
    .ctl_bit8  (ctl_bit8),
    .load_pre  (load_pre),
    .en_q      (en_q),
    .nine_q    (nine_q),
    .bit8_q    (bit8_q),
    .pre_q     (pre_q)
  );

  async_tx_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_we    (buf_we),
    .buf_wdata (buf_wdata),
    .xfer      (load_data),
    .data_q    (buf_data),
    .empty_q   (buf_empty)
  );

  async_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .en        (en_q),
    .nine      (nine_q),
    .bit8      (bit8_q),
    .pre_pend  (pre_q),
    .buf_full  (!buf_empty),
    .buf_data  (buf_data),
    .load_pre  (load_pre),
    .load_data (load_data),
    .busy      (busy),
    .txd_bit   (txd_bit)
  );

  assign txd    = txd_bit;
  assign txd_oe = en_q || busy || !buf_empty;
endmodule

// File: rtl/async_tx_checker.sv
module async_tx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_tick,
  input logic              buf_we,
  input logic              txd,
  input logic              txd_oe,
  input logic              buf_empty,
  input logic              busy,
  input logic              load_pre,
  input logic              load_data,
  input logic [DATA_W-1:0] buf_data
);
  assert_start_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_data |=> !txd);

  assert_preamble_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_pre |=> (txd && busy));

  assert_line_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> ($past(bit_tick) || $past(load_data) || $past(load_pre)));

  assert_empty_on_transfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $past(load_data));

  assert_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && !buf_empty && !load_data) |=> (!buf_empty && $stable(buf_data)));

  assert_release_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !txd_oe |-> (txd && buf_empty && !busy));
endmodule

bind async_tx_preamble async_tx_checker #(.DATA_W(DATA_W)) i_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_tick  (bit_tick),
  .buf_we    (buf_we),
  .txd       (txd),
  .txd_oe    (txd_oe),
  .buf_empty (buf_empty),
  .busy      (busy),
  .load_pre  (load_pre),
  .load_data (load_data),
  .buf_data  (buf_data)
);

// File: tb/test_async_tx_preamble.sv
`timescale 1ns/1ps
module test_async_tx_preamble;
  logic       clk;
  logic       rst_n;
  logic       bit_tick;
  logic       ctl_we, ctl_tx_en, ctl_nine, ctl_bit8;
  logic       buf_we;
  logic [7:0] buf_wdata;
  logic       txd, txd_oe, buf_empty;
  int         checks;
  int         errors;

  async_tx_preamble #(.DATA_W(8)) i_async_tx_preamble (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .ctl_we    (ctl_we),
    .ctl_tx_en (ctl_tx_en),
    .ctl_nine  (ctl_nine),
    .ctl_bit8  (ctl_bit8),
    .buf_we    (buf_we),
    .buf_wdata (buf_wdata),
    .txd       (txd),
    .txd_oe    (txd_oe),
    .buf_empty (buf_empty)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic write_ctl(input logic en, input logic nine, input logic b8);
    @(negedge clk);
    ctl_we = 1'b1; ctl_tx_en = en; ctl_nine = nine; ctl_bit8 = b8;
    @(negedge clk) ctl_we = 1'b0;
  endtask

  task automatic write_buf(input logic [7:0] d);
    @(negedge clk);
    buf_we = 1'b1; buf_wdata = d;
    @(negedge clk) buf_we = 1'b0;
  endtask

  function automatic logic [7:0] byte_of(input int k);
    return 8'(k) ^ 8'h5A;
  endfunction

  function automatic logic frame_bit(input logic [7:0] d, input int j,
                                     input logic nine, input logic b8);
    if (j == 0) return 1'b0;
    if (j <= 8) return d[j-1];
    if (j == 9 && nine) return b8;
    return 1'b1;
  endfunction

  task automatic run_mode(input logic nine, input logic b8);
    int flen;
    flen = nine ? 11 : 10;
    write_ctl(1'b1, nine, b8);
    @(negedge clk);
    chk("R7 oe on enable", 32'(txd_oe), 32'd1);
    write_buf(byte_of(0));
    chk("R4 flag cleared by write", 32'(buf_empty), 32'd0);
    for (int i = 0; i < flen; i++) begin
      chk("R2 preamble bit is one", 32'(txd), 32'd1);
      pulse_tick();
    end
    chk("R4 flag set on transfer", 32'(buf_empty), 32'd1);
    for (int k = 0; k < 256; k++) begin
      for (int j = 0; j < flen; j++) begin
        if (j == 0)
          chk("R6 start bit with no gap", 32'(txd), 32'd0);
        else
          chk("R3 frame bit", 32'(txd), 32'(frame_bit(byte_of(k), j, nine, b8)));
        if (j == 2 && k < 255) begin
          write_buf(byte_of(k + 1));
          chk("R4 flag cleared by refill", 32'(buf_empty), 32'd0);
          write_buf(~byte_of(k + 1));
          chk("R5 flag stays clear", 32'(buf_empty), 32'd0);
        end
        pulse_tick();
      end
    end
    chk("R7 idle line high", 32'(txd), 32'd1);
    chk("R7 oe while enabled", 32'(txd_oe), 32'd1);
    chk("R4 flag set at end", 32'(buf_empty), 32'd1);
    pulse_tick();
    chk("R7 idle line stays high", 32'(txd), 32'd1);
    write_ctl(1'b0, nine, b8);
    chk("R8 oe released", 32'(txd_oe), 32'd0);
    chk("R8 line idle", 32'(txd), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; bit_tick = 1'b0;
    ctl_we = 1'b0; ctl_tx_en = 1'b0; ctl_nine = 1'b0; ctl_bit8 = 1'b0;
    buf_we = 1'b0; buf_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset txd", 32'(txd), 32'd1);
    chk("R1 reset oe", 32'(txd_oe), 32'd0);
    chk("R1 reset flag", 32'(buf_empty), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    run_mode(1'b0, 1'b0);
    run_mode(1'b1, 1'b1);
    run_mode(1'b1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule